// File: doc/BRIEF.md
# Transfer Group Interrupt Flag Controller

This block is the register-side event and interrupt logic for one transfer group of a parallel digital I/O engine. The transfer datapath reports its events as pulses: a wait condition, a primary terminal count, a secondary terminal count and one pulse per completed transfer. It also reports a FIFO-not-empty level. The block turns these into sticky flags and combines them with per-flag enables into one interrupt request. The request is steered onto one of several interrupt lines.

Software reaches the block through a byte-wide register bus with eight offsets. Sticky flags are cleared through two write-only clear registers that have different bit layouts. The data-ready flag is not stored: it follows FIFO occupancy and no register write can change it. A transfer limit register sets how many completed transfers raise the count-expired flag. The internal counter then holds until the limit is written again.

Top module: `xfer_irq_flags`

## Requirements
- R1: After reset the sticky flags, interrupt enable, master control, transfer limit and transfer progress are all zero, no interrupt line is high, and neither reset pulse is asserted.
- R2: Reading offset 0 returns the flag byte: bit 7 secondary terminal count, bit 6 primary terminal count, bit 5 waited, bit 1 count expired, bit 0 data ready. Bits 4 to 2 read as zero. Bit 0 equals the `fifo_not_empty` input in the same cycle.
- R3: The waited, primary and secondary flags are set by a rising edge of `ev_wait`, `ev_ptc` and `ev_stc`. An input held high sets its flag once only; after a clear the flag stays clear until the next rising edge.
- R4: Writing offset 0 clears the flags that have a 1 in the written byte: bit 3 clears waited, bit 4 clears primary, bit 5 clears secondary. Bits 0 to 2 of that write have no effect, and a write to offset 0 never clears count expired.
- R5: Writing offset 0 with bit 6 set raises `dma_rst`, and with bit 7 set raises `fifo_rst`, each for exactly one cycle, starting the cycle after the write. Writing 0xF8 clears all three event flags and raises both resets.
- R6: Count expired is cleared only by writing offset 1 with bit 0 set.
- R7: When an event sets a flag in the same cycle as a write clears it, the flag ends up set.
- R8: Master control at offset 3 holds the line select in bits 1:0 and the interrupt enable in bit 2. Interrupt line N is high exactly when the enable bit is 1, the line select equals N, and some flag is 1 while its enable bit at offset 2 is also 1. The enable bits sit at the same positions as the flag bits. Writing 0 to offset 3 drops every line.
- R9: The data-ready flag cannot be cleared by writes: with `fifo_not_empty` high, writing 0xFF to offset 0 or offset 1 leaves flag bit 0 at 1.
- R10: The transfer limit is written little-endian at offsets 4 to 7. Any write there restarts the transfer progress from zero. Each cycle with `xfer_done` high counts one transfer. The count-expired flag sets on the transfer that makes the progress equal the limit. The progress then stops, so later transfers cannot set the flag again. A limit of zero never expires.
- R11: Reading offset 1 returns the status byte: bit 0 equals `fifo_not_empty`, bit 3 equals `stop_trig`, and the other bits are zero.
- R12: Offsets 2 and 3 read back the last byte written to them. Offsets 4 to 7 read back the transfer limit bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| fifo_not_empty | input | 1 | FIFO occupancy level from the datapath |
| stop_trig | input | 1 | Stop trigger level from the datapath |
| xfer_done | input | 1 | One completed transfer per cycle high |
| ev_wait | input | 1 | Wait condition event |
| ev_ptc | input | 1 | Primary terminal count event |
| ev_stc | input | 1 | Secondary terminal count event |
| irq_lines | output | 4 | Interrupt request, one selectable line |
| dma_rst | output | 1 | One-cycle DMA request logic reset |
| fifo_rst | output | 1 | One-cycle FIFO reset |

## Verification
The bench builds the block with its defaults: a 32-bit transfer limit and a 2-bit line select, so there are four interrupt lines. With these values all four limit bytes are present. A limit of 259 makes progress carry into the second byte, and that is reached in a few hundred cycles. Every line select value, the live data-ready bit, and the cycles where a set and a clear collide are each driven directly.

// File: rtl/xfer_irq_flags.sv
`timescale 1ns/1ps
module xfer_irq_flags #(
  parameter int CNT_W  = 32,
  parameter int LINE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              fifo_not_empty,
  input  logic              stop_trig,
  input  logic              xfer_done,
  input  logic              ev_wait,
  input  logic              ev_ptc,
  input  logic              ev_stc,
  output logic [(1<<LINE_W)-1:0] irq_lines,
  output logic              dma_rst,
  output logic              fifo_rst
);
  localparam int N_LINES   = 1 << LINE_W;
  localparam int CNT_BYTES = CNT_W / 8;
  localparam int EN_BIT    = LINE_W;
  localparam logic [2:0] A_FLAGS = 3'd0;
  localparam logic [2:0] A_AUX   = 3'd1;
  localparam logic [2:0] A_IEN   = 3'd2;
  localparam logic [2:0] A_MCTL  = 3'd3;

  logic [7:0] ien, mctl, flags;
  logic [CNT_W-1:0] limit, progress;
  logic q_wait, q_ptc, q_stc;
  logic f_wait, f_ptc, f_stc, f_cexp;

  wire wr_clr1  = bus_wr && (bus_addr == A_FLAGS);
  wire wr_clr2  = bus_wr && (bus_addr == A_AUX);
  wire cnt_load = bus_wr && bus_addr[2];
  wire rise_wait = ev_wait & ~q_wait;
  wire rise_ptc  = ev_ptc  & ~q_ptc;
  wire rise_stc  = ev_stc  & ~q_stc;
  wire at_limit  = (progress == limit);
  wire expire_now = xfer_done && !cnt_load && !at_limit &&
                    ((progress + CNT_W'(1)) == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wait <= 1'b0; q_ptc <= 1'b0; q_stc <= 1'b0;
    end else begin
      q_wait <= ev_wait; q_ptc <= ev_ptc; q_stc <= ev_stc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_wait <= 1'b0; f_ptc <= 1'b0; f_stc <= 1'b0; f_cexp <= 1'b0;
    end else begin
      if (rise_wait) f_wait <= 1'b1;
      else if (wr_clr1 && bus_wdata[3]) f_wait <= 1'b0;
      if (rise_ptc) f_ptc <= 1'b1;
      else if (wr_clr1 && bus_wdata[4]) f_ptc <= 1'b0;
      if (rise_stc) f_stc <= 1'b1;
      else if (wr_clr1 && bus_wdata[5]) f_stc <= 1'b0;
      if (expire_now) f_cexp <= 1'b1;
      else if (wr_clr2 && bus_wdata[0]) f_cexp <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_rst <= 1'b0; fifo_rst <= 1'b0;
    end else begin
      dma_rst  <= wr_clr1 && bus_wdata[6];
      fifo_rst <= wr_clr1 && bus_wdata[7];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= 8'h00; mctl <= 8'h00;
    end else if (bus_wr) begin
      if (bus_addr == A_IEN)  ien  <= bus_wdata;
      if (bus_addr == A_MCTL) mctl <= bus_wdata;
    end
  end

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_limit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) limit[8*b +: 8] <= 8'h00;
      else if (bus_wr && bus_addr == 3'(4 + b)) limit[8*b +: 8] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) progress <= '0;
    else if (cnt_load) progress <= '0;
    else if (xfer_done && !at_limit) progress <= progress + CNT_W'(1);
  end

  assign flags = {f_stc, f_ptc, f_wait, 3'b000, f_cexp, fifo_not_empty};

  wire irq_any = mctl[EN_BIT] && |(flags & ien);
  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    assign irq_lines[i] = irq_any && (mctl[LINE_W-1:0] == LINE_W'(i));
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      A_FLAGS: bus_rdata = flags;
      A_AUX:   bus_rdata = {4'b0000, stop_trig, 2'b00, fifo_not_empty};
      A_IEN:   bus_rdata = ien;
      A_MCTL:  bus_rdata = mctl;
      default: begin
        for (int b = 0; b < CNT_BYTES; b++)
          if (bus_addr == 3'(4 + b)) bus_rdata = limit[8*b +: 8];
      end
    endcase
  end

  assert_wait_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr1 && bus_wdata[3] && !rise_wait) |=> !f_wait);
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_wait && wr_clr1 && bus_wdata[3]) |=> f_wait);
  assert_cexp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cexp && !(wr_clr2 && bus_wdata[0])) |=> f_cexp);
  assert_progress_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    progress <= limit);
  assert_irq_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));
  assert_irq_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_MCTL && bus_wdata == 8'h00) |=> (irq_lines == '0));
  assert_reset_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst |=> !dma_rst || $past(wr_clr1 && bus_wdata[6]));
endmodule

// File: tb/tb_xfer_irq_flags.sv
`timescale 1ns/1ps
module tb_xfer_irq_flags;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00, bus_rdata;
  logic fifo_not_empty = 1'b0, stop_trig = 1'b0, xfer_done = 1'b0;
  logic ev_wait = 1'b0, ev_ptc = 1'b0, ev_stc = 1'b0;
  logic [3:0] irq_lines;
  logic dma_rst, fifo_rst;
  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  xfer_irq_flags dut (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fifo_not_empty(fifo_not_empty),
    .stop_trig(stop_trig), .xfer_done(xfer_done), .ev_wait(ev_wait), .ev_ptc(ev_ptc),
    .ev_stc(ev_stc), .irq_lines(irq_lines), .dma_rst(dma_rst), .fifo_rst(fifo_rst));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which) 0: ev_wait = 1'b1; 1: ev_ptc = 1'b1; 2: ev_stc = 1'b1; default: xfer_done = 1'b1; endcase
    @(negedge clk);
    ev_wait = 1'b0; ev_ptc = 1'b0; ev_stc = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); chk("R1 flags", d, 8'h00);
    rd(3'd2, d); chk("R1 ien", d, 8'h00);
    rd(3'd3, d); chk("R1 mctl", d, 8'h00);
    for (int b = 4; b < 8; b++) begin rd(3'(b), d); chk("R1 limit", d, 8'h00); end
    chk("R1 irq", irq_lines, 4'h0);
    chk("R1 resets", {dma_rst, fifo_rst}, 2'b00);
  endtask

  task automatic t_layout;
    logic [7:0] d;
    pulse(0); rd(3'd0, d); chk("R2 waited bit5", d, 8'h20);
    pulse(1); rd(3'd0, d); chk("R2 primary bit6", d, 8'h60);
    pulse(2); rd(3'd0, d); chk("R3 secondary bit7", d, 8'hE0);
    fifo_not_empty = 1'b1; rd(3'd0, d); chk("R2 ready bit0 live", d, 8'hE1);
    stop_trig = 1'b1; rd(3'd1, d); chk("R11 status", d, 8'h09);
    stop_trig = 1'b0; fifo_not_empty = 1'b0; rd(3'd1, d); chk("R11 status idle", d, 8'h00);
    fifo_not_empty = 1'b1;
  endtask

  task automatic t_clear1;
    logic [7:0] d;
    wr(3'd0, 8'h08); rd(3'd0, d); chk("R4 clear waited", d, 8'hC1);
    wr(3'd0, 8'h10); rd(3'd0, d); chk("R4 clear primary", d, 8'h81);
    wr(3'd0, 8'h07); rd(3'd0, d); chk("R4 low bits no effect", d, 8'h81);
    wr(3'd0, 8'h20); rd(3'd0, d); chk("R4 clear secondary", d, 8'h01);
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R9 ready survives clear1", d, 8'h01);
    wr(3'd1, 8'hFF); rd(3'd0, d); chk("R9 ready survives clear2", d, 8'h01);
    fifo_not_empty = 1'b0; rd(3'd0, d); chk("R2 ready follows fifo", d, 8'h00);
  endtask

  task automatic t_resets;
    logic [7:0] d;
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'h40; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; chk("R5 dma pulse", {dma_rst, fifo_rst}, 2'b10);
    @(negedge clk); chk("R5 dma pulse ends", {dma_rst, fifo_rst}, 2'b00);
    pulse(0); pulse(1); pulse(2);
    @(negedge clk); bus_addr = 3'd0; bus_wdata = 8'hF8; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; chk("R5 F8 both pulses", {dma_rst, fifo_rst}, 2'b11);
    @(negedge clk); chk("R5 pulses one cycle", {dma_rst, fifo_rst}, 2'b00);
    rd(3'd0, d); chk("R5 F8 clears flags", d, 8'h00);
  endtask

  task automatic t_level_and_collide;
    logic [7:0] d;
    @(negedge clk); ev_ptc = 1'b1;
    repeat (2) @(negedge clk);
    wr(3'd0, 8'h10);
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk("R3 held level no re-set", d, 8'h00);
    ev_ptc = 1'b0;
    pulse(1); rd(3'd0, d); chk("R3 new edge sets", d, 8'h40);
    wr(3'd0, 8'h10);
    @(negedge clk); ev_wait = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h08; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; ev_wait = 1'b0;
    rd(3'd0, d); chk("R7 set beats clear", d, 8'h20);
    wr(3'd0, 8'h08);
  endtask

  task automatic t_count;
    logic [7:0] d;
    wr(3'd4, 8'h03); rd(3'd4, d); chk("R12 limit readback", d, 8'h03);
    pulse(3); pulse(3); rd(3'd0, d); chk("R10 before limit", d, 8'h00);
    pulse(3); rd(3'd0, d); chk("R10 expired at limit", d, 8'h02);
    wr(3'd0, 8'hF8); rd(3'd0, d); chk("R6 clear1 keeps expired", d, 8'h02);
    wr(3'd1, 8'h01); rd(3'd0, d); chk("R6 clear2 clears", d, 8'h00);
    pulse(3); pulse(3); rd(3'd0, d); chk("R10 stopped no re-expire", d, 8'h00);
    wr(3'd4, 8'h03); pulse(3); pulse(3); pulse(3);
    rd(3'd0, d); chk("R10 restart after write", d, 8'h02);
    wr(3'd1, 8'h01);
    wr(3'd4, 8'h00);
    for (int k = 0; k < 5; k++) pulse(3);
    rd(3'd0, d); chk("R10 zero limit never expires", d, 8'h00);
    wr(3'd4, 8'h03); wr(3'd5, 8'h01);
    rd(3'd5, d); chk("R12 limit byte1", d, 8'h01);
    @(negedge clk); xfer_done = 1'b1;
    repeat (258) @(negedge clk);
    xfer_done = 1'b0;
    rd(3'd0, d); chk("R10 259 minus one", d, 8'h00);
    pulse(3); rd(3'd0, d); chk("R10 expire at 259", d, 8'h02);
    wr(3'd5, 8'h00); wr(3'd4, 8'h01);
    @(negedge clk); xfer_done = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0; xfer_done = 1'b0;
    rd(3'd0, d); chk("R7 expiry beats clear2", d, 8'h02);
    wr(3'd1, 8'h01);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    wr(3'd2, 8'h20); wr(3'd3, 8'h06); pulse(0);
    chk("R8 line 2", irq_lines, 4'b0100);
    wr(3'd3, 8'h05); chk("R8 line 1", irq_lines, 4'b0010);
    rd(3'd2, d); chk("R12 ien readback", d, 8'h20);
    rd(3'd3, d); chk("R12 mctl readback", d, 8'h05);
    wr(3'd3, 8'h00); chk("R8 master zero masks", irq_lines, 4'b0000);
    wr(3'd2, 8'h40); wr(3'd3, 8'h07); chk("R8 unenabled flag quiet", irq_lines, 4'b0000);
    wr(3'd0, 8'h08);
    wr(3'd2, 8'h01); wr(3'd3, 8'h04);
    fifo_not_empty = 1'b1; #1; chk("R8 ready on line 0", irq_lines, 4'b0001);
    fifo_not_empty = 1'b0; #1; chk("R8 ready gone", irq_lines, 4'b0000);
    wr(3'd2, 8'h02); wr(3'd4, 8'h01); pulse(3);
    @(negedge clk); chk("R8 expiry interrupt", irq_lines, 4'b0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_layout;
    t_clear1;
    t_resets;
    t_level_and_collide;
    t_count;
    t_irq;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule